// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for each beat of a four-beat cache-line burst. When a burst begins, the controller pulses a load strobe together with the two low bits of the starting word address. From then on, each clock edge with the active-low advance input asserted moves the block to the next beat. With advance released, the current beat is held, which suspends the burst. The beat address wraps inside the aligned four-word group, so after four steps it returns to the starting word.

A static order-select input picks one of two sequences. In linear order each beat is the start plus the beat count, modulo four. In interleaved order each beat is the start XOR the beat count. Alongside the address, the block reports a beat index that counts steps since the last load. The upper address bits, the storage array and the bus control logic sit outside this block.

Top module: `burst_seq_gen`

## Requirements
- R1: While reset is active, and on the first cycle after it, the beat address and the beat index are both 0.
- R2: A clock edge with `load_i` high captures `start_i`. After that edge the beat address equals the captured start and the beat index is 0.
- R3: With `order_i` low (linear order), each advance step makes the new beat address equal to the previous address plus 1, modulo 4. For example, a start of 2'b10 gives the sequence 10, 11, 00, 01.
- R4: With `order_i` high (interleaved order), the beat address is the start XOR the beat index. For example, a start of 2'b01 gives 01, 00, 11, 10, and a start of 2'b11 gives 11, 10, 01, 00.
- R5: A clock edge with `adv_n_i` low and `load_i` low raises the beat index by 1, modulo 4.
- R6: A clock edge with `adv_n_i` high and `load_i` low changes neither the beat address nor the beat index.
- R7: Four advance steps after a load, the beat address equals the start again and the beat index is back at 0.
- R8: When `load_i` is high on the same edge as an advance, or in the middle of a burst, the load takes priority. The sequence restarts from the new start with beat index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Burst start strobe, captures `start_i` |
| start_i | input | 2 | Low word-address bits of the first beat |
| adv_n_i | input | 1 | Advance enable, active low |
| order_i | input | 1 | Static order select: 0 linear, 1 interleaved |
| beat_addr_o | output | 2 | Word address of the current beat |
| beat_idx_o | output | 2 | Steps taken since the last load |

## Verification
The checker assumes `order_i` is a strap. It treats the input as constant from the release of reset onward, so the hold and step properties may compare addresses formed under the same order across cycles. The bench changes `order_i` only while reset is held, and then re-runs reset before any burst in the new order. The checker also treats `load_i` and `adv_n_i` as clean levels sampled at each edge. The bench drives them only on falling edges, away from the edges the design samples.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } order_e;
endpackage

// File: rtl/bsg_start_reg.sv
module bsg_start_reg #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start_in,
  output logic [AW-1:0] start_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    start_q <= '0;
    else if (load) start_q <= start_in;
  end
endmodule

// File: rtl/bsg_beat_ctr.sv
module bsg_beat_ctr #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [AW-1:0] count_q
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)     count_q <= '0;
    else if (clear) count_q <= '0;
    else if (step)  count_q <= count_q + ONE;
  end
endmodule

// File: rtl/bsg_order_map.sv
module bsg_order_map
  import burst_seq_pkg::*;
#(
  parameter int AW = 2
) (
  input  order_e        order,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] count,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] lin_addr;
  logic [AW-1:0] ilv_addr;

  assign lin_addr = base + count;
  assign ilv_addr = base ^ count;

  always_comb begin
    unique case (order)
      ORD_INTERLEAVED: addr = ilv_addr;
      default:         addr = lin_addr;
    endcase
  end
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
  import burst_seq_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] start_i,
  input  logic          adv_n_i,
  input  logic          order_i,
  output logic [AW-1:0] beat_addr_o,
  output logic [AW-1:0] beat_idx_o
);
  logic [AW-1:0] start_q;
  logic [AW-1:0] count_q;
  logic          step;
  order_e        order_sel;

  // Load wins over advance on the same edge.
  assign step      = !adv_n_i && !load_i;
  assign order_sel = order_e'(order_i);

  bsg_start_reg #(.AW(AW)) u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_i),
    .start_in (start_i),
    .start_q  (start_q)
  );

  bsg_beat_ctr #(.AW(AW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (load_i),
    .step    (step),
    .count_q (count_q)
  );

  bsg_order_map #(.AW(AW)) u_map (
    .order (order_sel),
    .base  (start_q),
    .count (count_q),
    .addr  (beat_addr_o)
  );

  assign beat_idx_o = count_q;
endmodule

// File: rtl/burst_seq_gen_chk.sv
module burst_seq_gen_chk #(
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_i,
  input logic [AW-1:0] start_i,
  input logic          adv_n_i,
  input logic          order_i,
  input logic [AW-1:0] beat_addr_o,
  input logic [AW-1:0] beat_idx_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |=> (beat_addr_o == '0) && (beat_idx_o == '0));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (beat_addr_o == $past(start_i)) && (beat_idx_o == '0));

  // R5
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n_i) |=> beat_idx_o == AW'($past(beat_idx_o) + ONE));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_n_i) |=> $stable(beat_idx_o) && $stable(beat_addr_o));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!order_i && !load_i && !adv_n_i) |=> beat_addr_o == AW'($past(beat_addr_o) + ONE));

  // R4
  interleave_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (order_i && !load_i && !adv_n_i) |=>
      ((beat_addr_o ^ $past(beat_addr_o)) == (beat_idx_o ^ $past(beat_idx_o))));
endmodule

bind burst_seq_gen burst_seq_gen_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .start_i     (start_i),
  .adv_n_i     (adv_n_i),
  .order_i     (order_i),
  .beat_addr_o (beat_addr_o),
  .beat_idx_o  (beat_idx_o)
);

// File: tb/burst_seq_gen_test.sv
module burst_seq_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_i;
  logic [1:0] start_i;
  logic       adv_n_i;
  logic       order_i;
  logic [1:0] beat_addr_o;
  logic [1:0] beat_idx_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  burst_seq_gen uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i),
    .adv_n_i(adv_n_i), .order_i(order_i),
    .beat_addr_o(beat_addr_o), .beat_idx_o(beat_idx_o)
  );

  task automatic check(input string req, input logic [1:0] exp_a, input logic [1:0] exp_i);
    checks++;
    if (beat_addr_o !== exp_a || beat_idx_o !== exp_i) begin
      errors++;
      $display("FAIL %s: addr=%b idx=%b expected addr=%b idx=%b",
               req, beat_addr_o, beat_idx_o, exp_a, exp_i);
    end
  endtask

  // Apply inputs on the falling edge, let one rising edge pass, sample on the next falling edge.
  task automatic cycle(input logic ld, input logic [1:0] st, input logic adv_n);
    load_i = ld; start_i = st; adv_n_i = adv_n;
    @(negedge clk);
  endtask

  function automatic logic [1:0] expect_addr(input logic ord, input logic [1:0] s, input logic [1:0] i);
    return ord ? (s ^ i) : 2'(s + i);
  endfunction

  task automatic do_reset(input logic ord);
    @(negedge clk);
    rst_n = 1'b0; order_i = ord; load_i = 1'b0; start_i = 2'b11; adv_n_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    check("R1 after reset", 2'b00, 2'b00);
    cycle(1'b0, 2'b10, 1'b1);
    check("R1 first cycle out of reset held", 2'b00, 2'b00);
  endtask

  task automatic t_full_burst(input logic ord, input logic [1:0] s);
    string req;
    req = ord ? "R4" : "R3";
    do_reset(ord);
    cycle(1'b1, s, 1'b1);
    check("R2 load capture", s, 2'b00);
    for (int k = 1; k < 4; k++) begin
      cycle(1'b0, 2'b00, 1'b0);
      check({req, " / R5 step"}, expect_addr(ord, s, 2'(k)), 2'(k));
    end
    cycle(1'b0, 2'b00, 1'b0);
    check("R7 wrap to start", s, 2'b00);
  endtask

  task automatic t_hold(input logic ord);
    do_reset(ord);
    cycle(1'b1, 2'b01, 1'b1);
    cycle(1'b0, 2'b00, 1'b0);
    for (int k = 0; k < 3; k++) begin
      cycle(1'b0, 2'b10, 1'b1);
      check("R6 hold with advance released", expect_addr(ord, 2'b01, 2'b01), 2'b01);
    end
    cycle(1'b0, 2'b00, 1'b0);
    check("R6 resume after suspend", expect_addr(ord, 2'b01, 2'b10), 2'b10);
  endtask

  task automatic t_restart;
    do_reset(1'b0);
    cycle(1'b1, 2'b00, 1'b1);
    cycle(1'b0, 2'b00, 1'b0);
    cycle(1'b0, 2'b00, 1'b0);
    check("R3 mid burst", 2'b10, 2'b10);
    cycle(1'b1, 2'b11, 1'b0);
    check("R8 load beats advance", 2'b11, 2'b00);
    cycle(1'b0, 2'b00, 1'b0);
    check("R8 sequence from new start", 2'b00, 2'b01);
  endtask

  initial begin
    rst_n = 1'b0; load_i = 1'b0; start_i = '0; adv_n_i = 1'b1; order_i = 1'b0;
    t_reset();
    t_full_burst(1'b0, 2'b00);
    t_full_burst(1'b0, 2'b10);
    t_full_burst(1'b1, 2'b01);
    t_full_burst(1'b1, 2'b11);
    t_hold(1'b0);
    t_hold(1'b1);
    t_restart();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule